// File: doc/BRIEF.md
# Two-Arm Coincidence Vertex Trigger

This block makes the first-level interaction decision for a detector with two arms placed on either side of the collision point. Each arm sends a one-cycle hit pulse together with the number of cells that fired. The arrival-time difference between the two pulses is a measure of where along the beam axis the collision happened. Each arm path first passes through its own alignment delay, counted in sample-clock cycles, which cancels fixed cable and electronics offsets.

A programmable window sets the accepted range of collision positions. A pair whose aligned time difference lies inside the window counts as a good event. A good event must then pass three multiplicity cuts: a minimum for each arm and a minimum for the sum of the two arms. When every cut passes, the block fires a level-0 trigger and a separate time-of-flight start trigger. Each is a one-cycle pulse, and a programmable dead time follows. A run-enable input gates only the trigger outputs. Three counters keep a tally of accepted events, timing rejections and multiplicity rejections.

Top module: `vct_top`

## Requirements
- R1: After reset both trigger outputs are low, and the summed multiplicity output and all three counters read zero.
- R2: Each arm pulse, together with the multiplicity that came with it, is delayed by its alignment setting (0 to MAX_DLY cycles). The aligned difference is e = (t_b + align_b) - (t_a + align_a).
- R3: A pair is timing-good only when |e| < win_cycles. Two aligned pulses in the same cycle have e = 0, so they are rejected when win_cycles is 0.
- R4: Once the first aligned pulse is seen, the block waits for the other arm. If `win_cycles` cycles pass first, it records one timing rejection and re-arms. A partner pulse that arrives exactly at that cycle is consumed by the rejection. Further pulses from the arm that arrived first are ignored during the wait.
- R5: A timing-good pair is accepted only when mult_a >= min_mult_a, mult_b >= min_mult_b and mult_a + mult_b >= min_mult_sum. Any other timing-good pair counts as a multiplicity rejection.
- R6: An acceptance makes `l0_trig` and `tof_trig` high together for exactly one cycle. That cycle is the one right after the cycle in which the later aligned pulse arrived.
- R7: After an acceptance, aligned pulses in the next `dead_cycles` cycles (the trigger cycle is the first of them) are ignored entirely. A setting of 0 gives no dead time.
- R8: While `run_en` is low, decisions and counters still work as normal, but neither trigger output fires.
- R9: Each decision adds exactly one to exactly one of `n_accept`, `n_rej_time` and `n_rej_mult`, and the count is visible in the same cycle the trigger would be.
- R10: `sum_mult` holds the two arm multiplicities added together for the most recent pair that passed the timing test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Enables the trigger outputs |
| arm_a_hit | input | 1 | One-cycle timing pulse from arm A |
| arm_a_mult | input | MW | Hit count of arm A, valid with its pulse |
| arm_b_hit | input | 1 | One-cycle timing pulse from arm B |
| arm_b_mult | input | MW | Hit count of arm B, valid with its pulse |
| align_a | input | clog2(MAX_DLY+1) | Alignment delay of arm A in cycles |
| align_b | input | clog2(MAX_DLY+1) | Alignment delay of arm B in cycles |
| win_cycles | input | WINW | Position window: accepted when abs difference is below this |
| min_mult_a | input | MW | Minimum hit count for arm A |
| min_mult_b | input | MW | Minimum hit count for arm B |
| min_mult_sum | input | MW+1 | Minimum summed hit count |
| dead_cycles | input | DTW | Dead time after an acceptance |
| l0_trig | output | 1 | Level-0 trigger pulse |
| tof_trig | output | 1 | Time-of-flight start pulse |
| sum_mult | output | MW+1 | Summed multiplicity of the last timed pair |
| n_accept | output | CW | Accepted-event count |
| n_rej_time | output | CW | Timing-rejection count |
| n_rej_mult | output | CW | Multiplicity-rejection count |

## Verification
The assertions assume that the window, the cut and the delay settings stay fixed while a wait or a dead period is running. They also assume each arm pulse lasts one cycle and that the multiplicity is valid only in that cycle. The stimulus changes configuration only in the long quiet gaps between events, when the block is idle. It places every pulse as a single cycle on a known cycle index, so the expected cycle of each trigger can be worked out from the delays alone.

// File: rtl/vct_pkg.sv
package vct_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_DEAD} vct_state_e;
   typedef enum logic [1:0] {DEC_NONE, DEC_ACC, DEC_REJ_T, DEC_REJ_M} vct_dec_e;
endpackage

// File: rtl/vct_align_dly.sv
module vct_align_dly #(
   parameter int MAX_DLY = 15,
   parameter int MW      = 8,
   localparam int DLYW   = $clog2(MAX_DLY + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hit_i,
   input  logic [MW-1:0]   mult_i,
   input  logic [DLYW-1:0] dly_i,
   output logic            hit_o,
   output logic [MW-1:0]   mult_o
);
   logic [MAX_DLY-1:0] hit_sr;
   logic [MW-1:0]      mult_sr [MAX_DLY];
   logic [DLYW-1:0]    sel;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit_sr <= '0;
         for (int i = 0; i < MAX_DLY; i++) mult_sr[i] <= '0;
      end else begin
         hit_sr[0]  <= hit_i;
         mult_sr[0] <= mult_i;
         for (int i = 1; i < MAX_DLY; i++) begin
            hit_sr[i]  <= hit_sr[i-1];
            mult_sr[i] <= mult_sr[i-1];
         end
      end
   end

   always_comb begin
      sel = (dly_i > DLYW'(MAX_DLY)) ? DLYW'(MAX_DLY) : dly_i;
      if (sel == '0) begin
         hit_o  = hit_i;
         mult_o = mult_i;
      end else begin
         hit_o  = hit_sr[sel - 1'b1];
         mult_o = mult_sr[sel - 1'b1];
      end
   end
endmodule

// File: rtl/vct_coinc_fsm.sv
module vct_coinc_fsm
   import vct_pkg::*;
#(
   parameter int MW   = 8,
   parameter int WINW = 6,
   parameter int DTW  = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hit_a,
   input  logic            hit_b,
   input  logic [MW-1:0]   mult_a,
   input  logic [MW-1:0]   mult_b,
   input  logic [WINW-1:0] win,
   input  logic [MW-1:0]   min_a,
   input  logic [MW-1:0]   min_b,
   input  logic [MW:0]     min_sum,
   input  logic [DTW-1:0]  dead_len,
   output vct_dec_e        dec_o,
   output logic [MW:0]     sum_o,
   output logic            in_dead_o
);
   vct_state_e      st, st_n;
   logic            first_a, first_n;
   logic [MW-1:0]   held, held_n;
   logic [WINW-1:0] elapsed, el_n;
   logic [DTW-1:0]  dead_cnt, dead_n;
   logic            pair, t_ok, other;
   logic [MW-1:0]   pm_a, pm_b;

   always_comb begin
      st_n = st; first_n = first_a; held_n = held; el_n = elapsed; dead_n = dead_cnt;
      dec_o = DEC_NONE; pair = 1'b0; t_ok = 1'b0;
      pm_a = mult_a; pm_b = mult_b;
      other = first_a ? hit_b : hit_a;
      case (st)
         ST_IDLE: begin
            if (hit_a && hit_b) begin
               pair = 1'b1;
               t_ok = (win != '0);
            end else if (hit_a || hit_b) begin
               st_n    = ST_WAIT;
               first_n = hit_a;
               held_n  = hit_a ? mult_a : mult_b;
               el_n    = WINW'(1);
            end
         end
         ST_WAIT: begin
            pm_a = first_a ? held : mult_a;
            pm_b = first_a ? mult_b : held;
            if (elapsed >= win) begin
               dec_o = DEC_REJ_T;
               st_n  = ST_IDLE;
            end else if (other) begin
               pair = 1'b1;
               t_ok = 1'b1;
            end else begin
               el_n = elapsed + 1'b1;
            end
         end
         ST_DEAD: begin
            if (dead_cnt <= DTW'(1)) st_n = ST_IDLE;
            else                     dead_n = dead_cnt - 1'b1;
         end
         default: st_n = ST_IDLE;
      endcase
      sum_o = {1'b0, pm_a} + {1'b0, pm_b};
      if (pair) begin
         st_n = ST_IDLE;
         if (!t_ok) begin
            dec_o = DEC_REJ_T;
         end else if (pm_a >= min_a && pm_b >= min_b && sum_o >= min_sum) begin
            dec_o = DEC_ACC;
            if (dead_len != '0) begin
               st_n   = ST_DEAD;
               dead_n = dead_len;
            end
         end else begin
            dec_o = DEC_REJ_M;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= ST_IDLE; first_a <= 1'b0; held <= '0; elapsed <= '0; dead_cnt <= '0;
      end else begin
         st <= st_n; first_a <= first_n; held <= held_n; elapsed <= el_n; dead_cnt <= dead_n;
      end
   end

   assign in_dead_o = (st == ST_DEAD);

   // R4: the wait never runs past the window
   a_r4_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT) |-> (elapsed <= win || elapsed == WINW'(1)));
   // R7: a dead period always ends in the idle state
   a_r7_dead_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DEAD && dead_cnt <= DTW'(1)) |=> (st == ST_IDLE));
endmodule

// File: rtl/vct_event_counters.sv
module vct_event_counters #(
   parameter int CW = 16,
   parameter int N  = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  inc_i,
   output logic [CW-1:0] cnt_o [N]
);
   for (genvar g = 0; g < N; g++) begin : g_cnt
      always_ff @(posedge clk) begin
         if (!rst_n)        cnt_o[g] <= '0;
         else if (inc_i[g]) cnt_o[g] <= cnt_o[g] + 1'b1;
      end
   end

   // R9: at most one outcome per cycle
   a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(inc_i));
endmodule

// File: rtl/vct_top.sv
module vct_top
   import vct_pkg::*;
#(
   parameter int MAX_DLY = 15,
   parameter int MW      = 8,
   parameter int WINW    = 6,
   parameter int DTW     = 8,
   parameter int CW      = 16,
   localparam int DLYW   = $clog2(MAX_DLY + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run_en,
   input  logic            arm_a_hit,
   input  logic [MW-1:0]   arm_a_mult,
   input  logic            arm_b_hit,
   input  logic [MW-1:0]   arm_b_mult,
   input  logic [DLYW-1:0] align_a,
   input  logic [DLYW-1:0] align_b,
   input  logic [WINW-1:0] win_cycles,
   input  logic [MW-1:0]   min_mult_a,
   input  logic [MW-1:0]   min_mult_b,
   input  logic [MW:0]     min_mult_sum,
   input  logic [DTW-1:0]  dead_cycles,
   output logic            l0_trig,
   output logic            tof_trig,
   output logic [MW:0]     sum_mult,
   output logic [CW-1:0]   n_accept,
   output logic [CW-1:0]   n_rej_time,
   output logic [CW-1:0]   n_rej_mult
);
   if (MAX_DLY < 1 || MW < 1 || WINW < 1 || DTW < 1 || CW < 1) begin : g_bad_cfg
      $error("vct_top: parameter out of range");
   end

   logic            hit_raw [2];
   logic [MW-1:0]   mult_raw [2];
   logic [DLYW-1:0] dly_raw [2];
   logic            hit_al [2];
   logic [MW-1:0]   mult_al [2];

   assign hit_raw[0] = arm_a_hit;  assign hit_raw[1] = arm_b_hit;
   assign mult_raw[0] = arm_a_mult; assign mult_raw[1] = arm_b_mult;
   assign dly_raw[0] = align_a;    assign dly_raw[1] = align_b;

   for (genvar g = 0; g < 2; g++) begin : g_arm
      vct_align_dly #(.MAX_DLY(MAX_DLY), .MW(MW)) u_dly (
         .clk(clk), .rst_n(rst_n), .hit_i(hit_raw[g]), .mult_i(mult_raw[g]),
         .dly_i(dly_raw[g]), .hit_o(hit_al[g]), .mult_o(mult_al[g]));
   end

   vct_dec_e    dec;
   logic [MW:0] fsm_sum;
   logic        in_dead;

   vct_coinc_fsm #(.MW(MW), .WINW(WINW), .DTW(DTW)) u_fsm (
      .clk(clk), .rst_n(rst_n), .hit_a(hit_al[0]), .hit_b(hit_al[1]),
      .mult_a(mult_al[0]), .mult_b(mult_al[1]), .win(win_cycles),
      .min_a(min_mult_a), .min_b(min_mult_b), .min_sum(min_mult_sum),
      .dead_len(dead_cycles), .dec_o(dec), .sum_o(fsm_sum), .in_dead_o(in_dead));

   logic [2:0]    inc;
   logic [CW-1:0] cnt [3];
   assign inc = {dec == DEC_REJ_M, dec == DEC_REJ_T, dec == DEC_ACC};

   vct_event_counters #(.CW(CW), .N(3)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc_i(inc), .cnt_o(cnt));

   assign n_accept   = cnt[0];
   assign n_rej_time = cnt[1];
   assign n_rej_mult = cnt[2];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         l0_trig  <= 1'b0;
         tof_trig <= 1'b0;
         sum_mult <= '0;
      end else begin
         l0_trig  <= (dec == DEC_ACC) && run_en;
         tof_trig <= (dec == DEC_ACC) && run_en;
         if (dec == DEC_ACC || dec == DEC_REJ_M) sum_mult <= fsm_sum;
      end
   end

   // R8: no trigger unless the run was enabled at the decision
   a_r8_run_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(run_en) |-> !l0_trig && !tof_trig);
   // R6: both triggers coincide
   a_r6_pair_out: assert property (@(posedge clk) disable iff (!rst_n) l0_trig == tof_trig);
   // R6: single-cycle pulse when a dead time is set
   a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (l0_trig && dead_cycles != '0) |=> !l0_trig);
   // R9: a trigger always comes with one more accepted event
   a_r9_acc_step: assert property (@(posedge clk) disable iff (!rst_n)
      l0_trig |-> n_accept == $past(n_accept) + 1'b1);
   // R7: counters are frozen across dead cycles
   a_r7_dead_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      in_dead |=> $stable(n_accept) && $stable(n_rej_time) && $stable(n_rej_mult));
endmodule

// File: tb/vct_top_tb_top.sv
module vct_top_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic run_en = 1'b1;
   logic arm_a_hit = 1'b0, arm_b_hit = 1'b0;
   logic [7:0] arm_a_mult = '0, arm_b_mult = '0;
   logic [3:0] align_a = '0, align_b = '0;
   logic [5:0] win_cycles = 6'd4;
   logic [7:0] min_mult_a = 8'd3, min_mult_b = 8'd3;
   logic [8:0] min_mult_sum = 9'd10;
   logic [7:0] dead_cycles = 8'd5;
   logic l0_trig, tof_trig;
   logic [8:0] sum_mult;
   logic [15:0] n_accept, n_rej_time, n_rej_mult;

   always #2 clk = ~clk;

   vct_top dut_i (.*);

   int cyc = 0, l0_n = 0, tof_n = 0, l0_cyc = -1;
   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) begin
      if (l0_trig)  begin l0_n++; l0_cyc = cyc; end
      if (tof_trig) tof_n++;
   end

   task automatic check(string req, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic drive(input int ta, input int ta2, input int tb, input int tb2,
                        input int ma, input int ma2, input int mb, output int base);
      @(negedge clk);
      base = cyc;
      for (int k = 0; k < 48; k++) begin
         arm_a_hit  = (k == ta) || (k == ta2);
         arm_a_mult = (k == ta) ? 8'(ma) : ((k == ta2) ? 8'(ma2) : 8'd0);
         arm_b_hit  = (k == tb) || (k == tb2);
         arm_b_mult = (arm_b_hit) ? 8'(mb) : 8'd0;
         @(negedge clk);
      end
      arm_a_hit = 0; arm_b_hit = 0; arm_a_mult = 0; arm_b_mult = 0;
   endtask

   typedef struct packed {
      logic [3:0] da, db;
      logic signed [7:0] gap;
      logic [7:0] ma, mb;
      logic run;
      logic [1:0] acc, rt, rm;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{4'd0, 4'd0,  8'sd0, 8'd5, 8'd6, 1'b1, 2'd1, 2'd0, 2'd0},
      '{4'd0, 4'd0,  8'sd3, 8'd5, 8'd6, 1'b1, 2'd1, 2'd0, 2'd0},
      '{4'd0, 4'd0, -8'sd3, 8'd5, 8'd6, 1'b1, 2'd1, 2'd0, 2'd0},
      '{4'd0, 4'd0,  8'sd4, 8'd5, 8'd6, 1'b1, 2'd0, 2'd1, 2'd0},
      '{4'd0, 4'd0, -8'sd6, 8'd5, 8'd6, 1'b1, 2'd0, 2'd2, 2'd0},
      '{4'd0, 4'd0,  8'sd2, 8'd2, 8'd9, 1'b1, 2'd0, 2'd0, 2'd1},
      '{4'd0, 4'd0,  8'sd1, 8'd5, 8'd4, 1'b1, 2'd0, 2'd0, 2'd1},
      '{4'd0, 4'd0,  8'sd0, 8'd3, 8'd7, 1'b1, 2'd1, 2'd0, 2'd0},
      '{4'd5, 4'd2,  8'sd2, 8'd5, 8'd6, 1'b1, 2'd1, 2'd0, 2'd0},
      '{4'd0, 4'd3,  8'sd1, 8'd5, 8'd6, 1'b1, 2'd0, 2'd1, 2'd0},
      '{4'd3, 4'd0,  8'sd0, 8'd5, 8'd6, 1'b0, 2'd1, 2'd0, 2'd0},
      '{4'd0, 4'd0, -8'sd4, 8'd5, 8'd6, 1'b1, 2'd0, 2'd1, 2'd0},
      '{4'd15,4'd15, 8'sd0, 8'd5, 8'd6, 1'b1, 2'd1, 2'd0, 2'd0},
      '{4'd0, 4'd0,  8'sd0, 8'd2, 8'd2, 1'b1, 2'd0, 2'd0, 2'd1},
      '{4'd0, 4'd0, -8'sd1, 8'd3, 8'd2, 1'b1, 2'd0, 2'd0, 2'd1}
   };

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      int base, a0, t0, m0, offa, offb, late;
      vec_t v;
      repeat (4) @(negedge clk);
      // R1: reset state
      check("R1 l0", int'(l0_trig), 0);
      check("R1 tof", int'(tof_trig), 0);
      check("R1 sum", int'(sum_mult), 0);
      check("R1 cnt", int'(n_accept) + int'(n_rej_time) + int'(n_rej_mult), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         v = VECS[i];
         align_a = v.da; align_b = v.db; run_en = v.run;
         @(negedge clk);
         a0 = n_accept; t0 = n_rej_time; m0 = n_rej_mult;
         l0_n = 0; tof_n = 0; l0_cyc = -1;
         offa = ($signed(v.gap) < 0) ? -int'($signed(v.gap)) : 0;
         offb = ($signed(v.gap) > 0) ?  int'($signed(v.gap)) : 0;
         late = (offa + int'(v.da) > offb + int'(v.db)) ? offa + int'(v.da) : offb + int'(v.db);
         drive(offa, -1, offb, -1, int'(v.ma), 0, int'(v.mb), base);
         check(v.rm != 0 ? "R5 accept" : "R3 accept", int'(n_accept) - a0, int'(v.acc));
         check("R9 time rejects", int'(n_rej_time) - t0, int'(v.rt));
         check("R5 mult rejects", int'(n_rej_mult) - m0, int'(v.rm));
         check(v.run ? "R6 l0 count" : "R8 l0 count", l0_n, int'(v.acc) * int'(v.run));
         check(v.run ? "R6 tof count" : "R8 tof count", tof_n, int'(v.acc) * int'(v.run));
         if (v.acc != 0 && v.run) check("R2 trigger cycle", l0_cyc, base + late + 1);
         if (v.acc != 0 || v.rm != 0) check("R10 sum", int'(sum_mult), int'(v.ma) + int'(v.mb));
      end

      align_a = 0; align_b = 0; run_en = 1;
      // R7: second pair five cycles later falls in dead time
      a0 = n_accept; t0 = n_rej_time; m0 = n_rej_mult; l0_n = 0;
      drive(0, 5, 0, 5, 5, 5, 6, base);
      check("R7 dead accept", int'(n_accept) - a0, 1);
      check("R7 dead others", int'(n_rej_time) - t0 + int'(n_rej_mult) - m0, 0);
      check("R7 dead l0", l0_n, 1);
      // R7: pair six cycles later is accepted
      a0 = n_accept; l0_n = 0;
      drive(0, 6, 0, 6, 5, 5, 6, base);
      check("R7 after dead", int'(n_accept) - a0, 2);
      check("R7 after dead l0", l0_n, 2);
      // R4: lone pulse times out
      a0 = n_accept; t0 = n_rej_time; l0_n = 0;
      drive(0, -1, -1, -1, 5, 0, 0, base);
      check("R4 timeout", int'(n_rej_time) - t0, 1);
      check("R4 no trig", l0_n + int'(n_accept) - a0, 0);
      // R4: repeat pulse from first arm ignored, first multiplicity kept
      a0 = n_accept; t0 = n_rej_time; l0_n = 0;
      drive(0, 2, 3, -1, 5, 1, 6, base);
      check("R4 repeat accept", int'(n_accept) - a0, 1);
      check("R4 repeat no reject", int'(n_rej_time) - t0, 0);
      check("R10 repeat sum", int'(sum_mult), 11);
      // R7: zero dead time, back-to-back pairs
      dead_cycles = 0;
      a0 = n_accept; l0_n = 0;
      drive(0, 1, 0, 1, 5, 5, 6, base);
      check("R7 no dead", int'(n_accept) - a0, 2);
      check("R6 back to back", l0_n, 2);
      // R3: zero window rejects even simultaneous pulses
      win_cycles = 0;
      a0 = n_accept; t0 = n_rej_time; l0_n = 0;
      drive(0, -1, 0, -1, 5, 0, 6, base);
      check("R3 zero window", int'(n_rej_time) - t0, 1);
      check("R3 zero window acc", int'(n_accept) - a0 + l0_n, 0);

      done = 1;
      summary();
      $finish;
   end
endmodule